// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 32K bytes (15 address lines, 8 data lines). The RAM has three active-low strobes (chip select, write strobe, output gate) and one shared data bus. The controller turns each single-byte host request into a timed strobe sequence. Each phase lasts a parameterised whole number of clock cycles, rounded up from the RAM's nanosecond limits for the chosen clock period. When no access is in progress, the RAM is deselected.

The host offers a request together with an address, a byte and a write flag. A request is taken only on a cycle where the controller shows ready, and ready is high only while the controller is idle. On a write, the controller holds the output gate off for the whole cycle. It drives the bus only after a short turnaround. It ends the write by raising chip select and write strobe together, and keeps the data and address on the bus for a hold phase after that edge. On a read, the controller samples the bus on the last cycle of the access window and returns the byte with a single-cycle valid pulse.

The bus is split into an output value, an output enable and an input value, ready for a pad cell at the chip edge.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is active and on the first cycle after it, ready is high, chip select, write strobe and output gate are all high (inactive), the bus enable is low and the read-valid flag is low.
- R2: Ready is high only in idle. Chip select is high whenever ready is high. A request is taken only on a clock edge where request and ready are both high, and the address, byte and write flag are latched at that edge. Later changes on those inputs, and requests held high while busy, do not create or alter an access.
- R3: A write spends SETUP_CYC cycles with all strobes high and the address driven. Chip select and write strobe then go low together for exactly PULSE_CYC cycles and rise on the same edge. The output gate stays high throughout, and ready returns SETUP_CYC+PULSE_CYC+HOLD_CYC cycles after acceptance (5 with the defaults).
- R4: During a write, the bus enable rises DRIVE_DLY_CYC cycles after the write strobe falls. It stays high, with the byte and the address unchanged, for HOLD_CYC cycles after the strobes rise. It is never high outside that window.
- R5: A read holds chip select and output gate low and write strobe high for exactly ACC_CYC cycles. The bus is sampled on the last of those cycles. All strobes are then high for TURN_CYC cycles before ready returns, SETUP_CYC+ACC_CYC+TURN_CYC cycles after acceptance.
- R6: The read-valid flag is high for exactly one cycle, SETUP_CYC+ACC_CYC cycles after acceptance. The read-data output then holds the byte stored at the requested address.
- R7: The bus enable is never high while the output gate is low, or in the cycle right after the output gate rises, so the controller and the RAM never drive the bus at the same time.
- R8: Every address from 0 to 2^ADDR_W-1, including both ends, reaches the RAM unaltered, so that a byte written there reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (15) | Byte address |
| wdata_i | input | DATA_W (8) | Byte to write |
| rdy_o | output | 1 | Controller idle; a request is taken this cycle |
| rdata_o | output | DATA_W (8) | Byte returned by the last read |
| rvalid_o | output | 1 | One-cycle pulse, rdata_o is new |
| ram_addr_o | output | ADDR_W (15) | RAM address lines |
| ram_ce_n_o | output | 1 | RAM chip select, active low |
| ram_we_n_o | output | 1 | RAM write strobe, active low |
| ram_oe_n_o | output | 1 | RAM output gate, active low |
| ram_dq_o | output | DATA_W (8) | Value for the data bus |
| ram_dq_oe_o | output | 1 | Drive ram_dq_o onto the data bus |
| ram_dq_i | input | DATA_W (8) | Value seen on the data bus |

## Verification
A behavioural RAM model returns a junk byte until the access window has run its full length. A read sampled too early therefore shows up as wrong data, apart from a late one. Directed pairs of a read followed by a write, and of a write followed by a read, stress bus turnaround. A write issued while a request is held high throughout the access shows whether a busy request is ignored or wrongly taken. Writes and reads at address 0 and at the top address check the address path. Seeded random mixes over a small window make repeated overwrites and read-backs compare against a scoreboard.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RTURN
  } ctl_state_e;

  // Whole clock cycles that cover a time in picoseconds, never below one.
  function automatic int ns_to_cyc(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Counter width able to hold the largest phase length minus one.
  function automatic int cnt_width(input int a, input int b, input int c,
                                   input int d, input int e);
    int m;
    m = max2(max2(max2(a, b), max2(c, d)), e);
    return max2(1, $clog2(m));
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt_d,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_comb begin
    if (load)                cnt_d = load_val;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int SETUP_CYC     = 1,
  parameter int PULSE_CYC     = 3,
  parameter int DRIVE_DLY_CYC = 1,
  parameter int HOLD_CYC      = 1,
  parameter int ACC_CYC       = 3,
  parameter int TURN_CYC      = 1,
  parameter int CW            = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic wr_i,
  output logic rdy_o,
  output logic accept_o,
  output logic capture_o,
  output logic ce_n_o,
  output logic we_n_o,
  output logic oe_n_o,
  output logic dq_oe_o
);
  localparam logic [CW-1:0] L_SETUP = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] L_PULSE = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] L_HOLD  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] L_ACC   = CW'(ACC_CYC - 1);
  localparam logic [CW-1:0] L_TURN  = CW'(TURN_CYC - 1);
  // Bus drive begins once the pulse counter has fallen to this value.
  localparam logic [CW-1:0] L_DRV   = CW'(PULSE_CYC - 1 - DRIVE_DLY_CYC);

  ctl_state_e    state_q, state_d;
  logic          wr_q;
  logic          load;
  logic [CW-1:0] load_val;
  logic [CW-1:0] cnt_d;
  logic          done;

  asram_timer #(.CW(CW)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .cnt_d    (cnt_d),
    .done     (done)
  );

  assign rdy_o    = (state_q == ST_IDLE);
  assign accept_o = req_i && rdy_o;

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    load_val  = '0;
    capture_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept_o) begin
        state_d = ST_SETUP;  load = 1'b1;  load_val = L_SETUP;
      end
      ST_SETUP: if (done) begin
        load = 1'b1;
        if (wr_q) begin state_d = ST_WPULSE; load_val = L_PULSE; end
        else      begin state_d = ST_RACC;   load_val = L_ACC;   end
      end
      ST_WPULSE: if (done) begin
        state_d = ST_WHOLD;  load = 1'b1;  load_val = L_HOLD;
      end
      ST_WHOLD: if (done) state_d = ST_IDLE;
      ST_RACC: if (done) begin
        capture_o = 1'b1;
        state_d   = ST_RTURN;  load = 1'b1;  load_val = L_TURN;
      end
      ST_RTURN: if (done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      ce_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) wr_q <= wr_i;
      // Strobes leave flops decoded from the next state: no decode glitches.
      ce_n_o  <= !((state_d == ST_WPULSE) || (state_d == ST_RACC));
      we_n_o  <= !(state_d == ST_WPULSE);
      oe_n_o  <= !(state_d == ST_RACC);
      dq_oe_o <= ((state_d == ST_WPULSE) && (cnt_d <= L_DRV)) ||
                 (state_d == ST_WHOLD);
    end
  end

  // R3
  we_with_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_o |-> !ce_n_o);
  // R3
  oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_o |-> oe_n_o);
  // R4
  hold_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_o) |-> dq_oe_o);
  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_o |-> (oe_n_o && $past(oe_n_o)));
  // R2
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> (ce_n_o && !dq_oe_o));
  // R5
  read_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_o |-> (!ce_n_o && we_n_o));
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_addr_o <= '0;
      dq_o       <= '0;
      rdata_o    <= '0;
      rvalid_o   <= 1'b0;
    end else begin
      if (accept) begin
        ram_addr_o <= addr_i;
        dq_o       <= wdata_i;
      end
      if (capture) rdata_o <= dq_i;
      rvalid_o <= capture;
    end
  end

  // R6
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |=> !rvalid_o);
  // R6
  rdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid_o |-> $stable(rdata_o));
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PS        = 4000,
  parameter int T_WE_PS       = 8000,
  parameter int T_DS_PS       = 6000,
  parameter int T_ACC_PS      = 12000,
  parameter int SETUP_CYC     = 1,
  parameter int DRIVE_DLY_CYC = 1,
  parameter int PULSE_CYC     = max2(ns_to_cyc(T_WE_PS, CLK_PS),
                                     DRIVE_DLY_CYC + ns_to_cyc(T_DS_PS, CLK_PS)),
  parameter int HOLD_CYC      = 1,
  parameter int ACC_CYC       = ns_to_cyc(T_ACC_PS, CLK_PS),
  parameter int TURN_CYC      = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_ce_n_o,
  output logic              ram_we_n_o,
  output logic              ram_oe_n_o,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe_o,
  input  logic [DATA_W-1:0] ram_dq_i
);
  localparam int CW = cnt_width(SETUP_CYC, PULSE_CYC, HOLD_CYC, ACC_CYC, TURN_CYC);

  logic accept;
  logic capture;

  asram_fsm #(
    .SETUP_CYC     (SETUP_CYC),
    .PULSE_CYC     (PULSE_CYC),
    .DRIVE_DLY_CYC (DRIVE_DLY_CYC),
    .HOLD_CYC      (HOLD_CYC),
    .ACC_CYC       (ACC_CYC),
    .TURN_CYC      (TURN_CYC),
    .CW            (CW)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .wr_i      (wr_i),
    .rdy_o     (rdy_o),
    .accept_o  (accept),
    .capture_o (capture),
    .ce_n_o    (ram_ce_n_o),
    .we_n_o    (ram_we_n_o),
    .oe_n_o    (ram_oe_n_o),
    .dq_oe_o   (ram_dq_oe_o)
  );

  asram_datapath #(.AW(ADDR_W), .DW(DATA_W)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .capture    (capture),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .dq_i       (ram_dq_i),
    .ram_addr_o (ram_addr_o),
    .dq_o       (ram_dq_o),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  // R4
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_o && !accept) |=> $stable(ram_addr_o));
endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb_top;
  // Phase lengths restated from the timing limits at a 4 ns clock.
  function automatic int up_cyc(input int t_ps);
    int n;
    n = 0;
    while (n * 4000 < t_ps) n++;
    return (n < 1) ? 1 : n;
  endfunction

  localparam int SETUP = 1;
  localparam int DRIVE = 1;
  localparam int HOLD  = 1;
  localparam int TURN  = 1;
  localparam int PULSE = (up_cyc(8000) > DRIVE + up_cyc(6000)) ?
                         up_cyc(8000) : DRIVE + up_cyc(6000);
  localparam int ACC   = up_cyc(12000);

  function automatic int wr_lat();  return SETUP + PULSE + HOLD; endfunction
  function automatic int rd_lat();  return SETUP + ACC;          endfunction

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rdy, rvalid;
  logic [7:0]  rdata;
  logic [14:0] ram_addr;
  logic        ce_n, we_n, oe_n, dq_oe;
  logic [7:0]  dq_o, dq_i;

  always #2 clk = ~clk;

  asram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdy_o(rdy), .rdata_o(rdata), .rvalid_o(rvalid),
    .ram_addr_o(ram_addr), .ram_ce_n_o(ce_n), .ram_we_n_o(we_n),
    .ram_oe_n_o(oe_n), .ram_dq_o(dq_o), .ram_dq_oe_o(dq_oe), .ram_dq_i(dq_i)
  );

  // ---------------- behavioural RAM model ----------------
  logic [7:0] mem [int];
  logic [7:0] exp_mem [int];

  function automatic logic [7:0] mem_peek(input logic [14:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_peek(input logic [14:0] a);
    if (exp_mem.exists(int'(a))) return exp_mem[int'(a)];
    return 8'h00;
  endfunction

  wire ram_rd = !ce_n && we_n && !oe_n;
  int  rd_age = 0;
  always @(posedge clk) rd_age <= ram_rd ? rd_age + 1 : 0;
  assign dq_i = (ram_rd && rd_age >= ACC - 1) ? mem_peek(ram_addr) : 8'hA5;

  int v_cont = 0, v_oe = 0, v_len = 0, v_hold = 0, v_addr = 0, v_stray = 0, v_idle = 0;
  int n_wr_model = 0, n_wr_issued = 0;
  bit p_act = 0, p_drv = 0, act, drv;
  int wcyc = 0, dcyc = 0;
  logic [14:0] waddr = '0;
  logic [7:0]  wlast = '0;

  always @(negedge clk) if (rst_n) begin
    act = !ce_n && !we_n;
    drv = ram_rd;
    if (dq_oe && (drv || p_drv)) v_cont++;
    if (!we_n && !oe_n) v_oe++;
    if (rdy && !ce_n) v_idle++;
    if (dq_oe && !act && !p_act) v_stray++;
    if (act) begin
      if (p_act && ram_addr != waddr) v_addr++;
      waddr = ram_addr;
      wcyc++;
      if (dq_oe) begin dcyc++; wlast = dq_o; end
    end else if (p_act) begin
      if (!dq_oe || dq_o != wlast || ram_addr != waddr) v_hold++;
      if (wcyc != PULSE || dcyc != PULSE - DRIVE) v_len++;
      mem[int'(waddr)] = wlast;
      n_wr_model++;
      wcyc = 0; dcyc = 0;
    end
    p_act = act; p_drv = drv;
  end

  // ---------------- checking ----------------
  int n_tests = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d, input bit hold_req);
    int lat;
    @(negedge clk); req = 1; wr = 1; addr = a; wdata = d;
    while (!rdy) @(negedge clk);
    exp_mem[int'(a)] = d;
    n_wr_issued++;
    @(negedge clk);
    if (hold_req) begin addr = a ^ 15'h0001; wdata = ~d; end
    else begin req = 0; addr = 15'($urandom); wdata = 8'($urandom); end
    chk(!rdy, "R2 ready low while writing", int'(rdy), 0);
    lat = -1;
    for (int i = 1; i <= 20 && lat < 0; i++) begin
      @(negedge clk);
      if (rdy) begin lat = i; req = 0; end
    end
    chk(lat == wr_lat(), "R3 write length", lat, wr_lat());
    chk(ce_n, "R2 deselect after write", int'(ce_n), 1);
  endtask

  task automatic do_read(input logic [14:0] a);
    int lat;
    logic [7:0] got;
    @(negedge clk); req = 1; wr = 0; addr = a; wdata = 8'($urandom);
    while (!rdy) @(negedge clk);
    @(negedge clk); req = 0; wr = 1; addr = 15'($urandom); wdata = 8'($urandom);
    chk(!rdy, "R2 ready low while reading", int'(rdy), 0);
    lat = -1; got = '0;
    for (int i = 1; i <= 20 && lat < 0; i++) begin
      @(negedge clk);
      if (rvalid) begin lat = i; got = rdata; end
    end
    chk(lat == rd_lat(), "R6 valid latency", lat, rd_lat());
    chk(got == exp_peek(a), "R5 read data", int'(got), int'(exp_peek(a)));
    @(negedge clk);
    chk(!rvalid, "R6 valid single cycle", int'(rvalid), 0);
    chk(rdy, "R5 turnaround length", int'(rdy), 1);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset values seen while reset is held
    chk(rdy && ce_n && we_n && oe_n && !dq_oe && !rvalid, "R1 reset outputs",
        {rdy, ce_n, we_n, oe_n, dq_oe, rvalid}, 6'b111100);
    rst_n = 1;
    @(negedge clk);
    chk(rdy && ce_n && we_n && oe_n && !dq_oe && !rvalid, "R1 first cycle after reset",
        {rdy, ce_n, we_n, oe_n, dq_oe, rvalid}, 6'b111100);

    // R8 both ends of the address space
    do_write(15'h0000, 8'h3C, 0);
    do_write(15'h7FFF, 8'hC3, 0);
    do_read(15'h7FFF);
    do_read(15'h0000);
    // R7 read straight into write, write straight into read
    do_write(15'h0010, 8'h5A, 0);
    do_read(15'h0010);
    do_write(15'h0011, 8'h96, 0);
    do_read(15'h0011);
    // R2 request held high while busy must not start a second write
    do_write(15'h0020, 8'h11, 0);
    do_write(15'h0021, 8'h22, 0);
    do_write(15'h0020, 8'h77, 1);
    do_read(15'h0021);
    do_read(15'h0020);

    for (int n = 0; n < 400; n++) begin
      logic [14:0] a;
      a = (($urandom % 16) == 0) ? 15'h7FF0 | 15'($urandom % 16) : 15'($urandom % 64);
      if ($urandom % 2) do_write(a, 8'($urandom), 0);
      else              do_read(a);
    end

    repeat (4) @(negedge clk);
    chk(v_cont == 0, "R7 bus contention events", v_cont, 0);
    chk(v_oe == 0, "R3 output gate low during write", v_oe, 0);
    chk(v_len == 0, "R3 strobe or drive length", v_len, 0);
    chk(v_hold == 0, "R4 data or address hold", v_hold, 0);
    chk(v_addr == 0, "R4 address moved during write", v_addr, 0);
    chk(v_stray == 0, "R4 bus driven outside write", v_stray, 0);
    chk(v_idle == 0, "R2 selected while idle", v_idle, 0);
    chk(n_wr_model == n_wr_issued, "R2 writes seen by RAM", n_wr_model, n_wr_issued);
    done_flag = 1;
    report();
  end
endmodule